// File: doc/BRIEF.md
# External-Memory FIFO Pointer Controller

This block keeps the bookkeeping for a first-in first-out queue whose storage is a window of a larger external memory. A producer pulses a write strobe for each word it has placed in the window, and a consumer pulses a read strobe for each word it has taken out. The block answers with the memory word address where the next write should land, the address of the next word to read, and the number of words currently held.

The window starts at a base word address fixed by a parameter and holds a power-of-two number of entries. Both pointers wrap inside the window. Two flags tell the neighbours when they may proceed. The write flag stays high while the fill count is below a write limit. The read flag is high only while the fill count is strictly above a read limit. Both limits are parameters. With the default limits the flags act as plain not-full and not-empty. A nonzero read limit holds back the consumer until a reserve of words has built up. The block never blocks a strobe itself: the callers must respect the flags.

The memory command ports and the data movers that use these addresses are outside this block.

Top module: `extmem_fifo_ptrctl`

## Requirements
- R1: After reset, both addresses equal the base address (both pointers are 0) and the fill count is 0.
- R2: Each clock edge at which the write strobe is high advances the write pointer by one, and the new address appears after that edge. An edge with the strobe low leaves the write address unchanged.
- R3: Each clock edge at which the read strobe is high advances the read pointer by one, and the new address appears after that edge. An edge with the strobe low leaves the read address unchanged.
- R4: Pointers wrap modulo the depth. With depth 16, 24 write strobes leave the write pointer at 8.
- R5: The fill count rises by one for a write alone and falls by one for a read alone. It is unchanged when both strobes are high together or both are low. It updates after the same edge as the pointers.
- R6: The write flag is combinational from the fill count and is high exactly when the count is less than the write limit.
- R7: The read flag is combinational from the fill count and is high exactly when the count is greater than the read limit.
- R8: The default limits are a read limit of 0 and a write limit equal to the depth. The write flag is then low at count = depth, and the read flag is low at count 0.
- R9: Each presented address is the base address plus the pointer, and always lies within base .. base+depth-1.
- R10: A write strobe given while the write flag is low still advances the write pointer and the fill count. The block does no gating of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_strobe | input | 1 | One word was written this cycle |
| rd_strobe | input | 1 | One word was read this cycle |
| wr_addr | output | ADDR_W | Memory word address for the next write |
| rd_addr | output | ADDR_W | Memory word address for the next read |
| fill_level | output | $clog2(DEPTH)+1 | Words currently held |
| can_write | output | 1 | Fill count is below the write limit |
| can_read | output | 1 | Fill count is above the read limit |

## Verification
The addresses and the fill count are registered, so each responds one clock edge after a strobe is sampled. Both flags follow the fill count with no further register, so they are due in that same cycle. The bench drives each strobe on a falling edge, lets one rising edge pass, and samples every output on the next falling edge. All values are checked there against a count kept in the bench. A second instance has a read limit of 4, a write limit of 12 and a different base address. It receives the same strobes, so both limit edges and the gating-free behaviour are checked on one stimulus.

// File: rtl/fifoptr_pkg.sv
package fifoptr_pkg;

   typedef enum logic [1:0] {
      LV_HOLD = 2'd0,
      LV_INC  = 2'd1,
      LV_DEC  = 2'd2
   } level_op_e;

   function automatic level_op_e level_op(input logic push, input logic pop);
      level_op_e op;
      unique case ({push, pop})
         2'b10:   op = LV_INC;
         2'b01:   op = LV_DEC;
         default: op = LV_HOLD;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/fptr_wrap_counter.sv
module fptr_wrap_counter #(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [PTR_W-1:0] ptr
);
   // DEPTH is a power of two, so the natural roll-over of PTR_W bits wraps the pointer.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ptr <= '0;
      else if (step)
         ptr <= ptr + PTR_W'(1);
   end
endmodule

// File: rtl/fptr_level_counter.sv
module fptr_level_counter
   import fifoptr_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int LVL_W = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   output logic [LVL_W-1:0] level
);
   level_op_e op;

   always_comb op = level_op(push, pop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         level <= '0;
      else begin
         unique case (op)
            LV_INC:  level <= level + LVL_W'(1);
            LV_DEC:  level <= level - LVL_W'(1);
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/fptr_thresh_flags.sv
module fptr_thresh_flags #(
   parameter int DEPTH     = 16,
   parameter int RD_THRESH = 0,
   parameter int WR_THRESH = DEPTH,
   localparam int LVL_W    = $clog2(DEPTH) + 1
) (
   input  logic [LVL_W-1:0] level,
   output logic             can_write,
   output logic             can_read
);
   localparam logic [LVL_W-1:0] WR_LIM = LVL_W'(WR_THRESH);
   localparam logic [LVL_W-1:0] RD_LIM = LVL_W'(RD_THRESH);

   // Write side: the limit at depth only needs the top bit, since level never exceeds depth.
   generate
      if (WR_THRESH == DEPTH) begin : g_wr_full
         always_comb can_write = ~level[LVL_W-1];
      end else begin : g_wr_cmp
         always_comb can_write = (level < WR_LIM);
      end
   endgenerate

   // Read side: a zero limit reduces to a non-zero test.
   generate
      if (RD_THRESH == 0) begin : g_rd_empty
         always_comb can_read = |level;
      end else begin : g_rd_cmp
         always_comb can_read = (level > RD_LIM);
      end
   endgenerate
endmodule

// File: rtl/fptr_addr_map.sv
module fptr_addr_map #(
   parameter int          DEPTH     = 16,
   parameter int          ADDR_W    = 32,
   parameter int unsigned BASE_ADDR = 0,
   localparam int         PTR_W     = $clog2(DEPTH)
) (
   input  logic [PTR_W-1:0]  ptr,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
   localparam logic [PTR_W-1:0]  BASE_LO = BASE_V[PTR_W-1:0];

   generate
      if (BASE_ADDR == 0) begin : g_zero
         always_comb addr = {{(ADDR_W-PTR_W){1'b0}}, ptr};
      end else if (BASE_LO == '0) begin : g_aligned
         // Window aligned to its size: concatenate instead of add.
         always_comb addr = {BASE_V[ADDR_W-1:PTR_W], ptr};
      end else begin : g_offset
         always_comb addr = BASE_V + {{(ADDR_W-PTR_W){1'b0}}, ptr};
      end
   endgenerate
endmodule

// File: rtl/extmem_fifo_ptrctl.sv
module extmem_fifo_ptrctl #(
   parameter int unsigned BASE_ADDR = 8,
   parameter int          DEPTH     = 16,
   parameter int          ADDR_W    = 32,
   parameter int          RD_THRESH = 0,
   parameter int          WR_THRESH = DEPTH,
   localparam int         PTR_W     = $clog2(DEPTH),
   localparam int         LVL_W     = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_strobe,
   input  logic              rd_strobe,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [LVL_W-1:0]  fill_level,
   output logic              can_write,
   output logic              can_read
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (ADDR_W <= PTR_W) begin : g_bad_addr
         $error("ADDR_W must exceed the pointer width");
      end
      if (WR_THRESH < 0 || WR_THRESH > DEPTH) begin : g_bad_wr
         $error("WR_THRESH must lie in 0..DEPTH");
      end
      if (RD_THRESH < 0 || RD_THRESH >= DEPTH) begin : g_bad_rd
         $error("RD_THRESH must lie in 0..DEPTH-1");
      end
   endgenerate

   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;

   fptr_wrap_counter #(.DEPTH(DEPTH)) u_wr_ptr (
      .clk(clk), .rst_n(rst_n), .step(wr_strobe), .ptr(wr_ptr)
   );

   fptr_wrap_counter #(.DEPTH(DEPTH)) u_rd_ptr (
      .clk(clk), .rst_n(rst_n), .step(rd_strobe), .ptr(rd_ptr)
   );

   fptr_addr_map #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_wr_map (
      .ptr(wr_ptr), .addr(wr_addr)
   );

   fptr_addr_map #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_rd_map (
      .ptr(rd_ptr), .addr(rd_addr)
   );

   fptr_level_counter #(.DEPTH(DEPTH)) u_level (
      .clk(clk), .rst_n(rst_n), .push(wr_strobe), .pop(rd_strobe), .level(fill_level)
   );

   fptr_thresh_flags #(.DEPTH(DEPTH), .RD_THRESH(RD_THRESH), .WR_THRESH(WR_THRESH)) u_flags (
      .level(fill_level), .can_write(can_write), .can_read(can_read)
   );
endmodule

// File: rtl/extmem_fifo_ptrctl_chk.sv
module extmem_fifo_ptrctl_chk #(
   parameter int unsigned BASE_ADDR = 8,
   parameter int          DEPTH     = 16,
   parameter int          ADDR_W    = 32,
   localparam int         PTR_W     = $clog2(DEPTH),
   localparam int         LVL_W     = PTR_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_strobe,
   input logic              rd_strobe,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [LVL_W-1:0]  fill_level,
   input logic              can_write,
   input logic              can_read
);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(DEPTH);

   logic [ADDR_W-1:0] wr_rel, rd_rel;
   logic [PTR_W-1:0]  wr_off, rd_off;

   always_comb begin
      wr_rel = wr_addr - BASE_V;
      rd_rel = rd_addr - BASE_V;
      wr_off = wr_rel[PTR_W-1:0];
      rd_off = rd_rel[PTR_W-1:0];
   end

   a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (fill_level == '0 && wr_addr == BASE_V && rd_addr == BASE_V));

   a_r2_wr_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> wr_off == $past(wr_off) + PTR_W'(1));

   a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_strobe |=> $stable(wr_addr));

   a_r3_rd_step: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |=> rd_off == $past(rd_off) + PTR_W'(1));

   a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> $stable(rd_addr));

   a_r5_level_up: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && !rd_strobe) |=> fill_level == $past(fill_level) + LVL_W'(1));

   a_r5_level_down: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !wr_strobe) |=> fill_level == $past(fill_level) - LVL_W'(1));

   a_r5_level_same: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe == rd_strobe) |=> $stable(fill_level));

   a_r6_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_level == LVL_W'(DEPTH)) |-> !can_write);

   a_r7_empty_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_level == '0) |-> !can_read);

   a_r9_addr_in_region: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rel < SPAN) && (rd_rel < SPAN));
endmodule

bind extmem_fifo_ptrctl extmem_fifo_ptrctl_chk #(
   .BASE_ADDR(BASE_ADDR), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
   .wr_addr(wr_addr), .rd_addr(rd_addr), .fill_level(fill_level),
   .can_write(can_write), .can_read(can_read)
);

// File: tb/test_extmem_fifo_ptrctl.sv
`timescale 1ns/1ps
module test_extmem_fifo_ptrctl;
   localparam int M_BASE = 8;
   localparam int T_BASE = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr = 1'b0, rd = 1'b0;
   logic [31:0] m_wa, m_ra, t_wa, t_ra;
   logic [4:0]  m_lv, t_lv;
   logic m_cw, m_cr, t_cw, t_cr;
   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   extmem_fifo_ptrctl #(.BASE_ADDR(M_BASE), .DEPTH(16)) i_extmem_fifo_ptrctl (
      .clk(clk), .rst_n(rst_n), .wr_strobe(wr), .rd_strobe(rd),
      .wr_addr(m_wa), .rd_addr(m_ra), .fill_level(m_lv), .can_write(m_cw), .can_read(m_cr));

   extmem_fifo_ptrctl #(.BASE_ADDR(T_BASE), .DEPTH(16), .RD_THRESH(4), .WR_THRESH(12))
   i_extmem_fifo_ptrctl_thr (
      .clk(clk), .rst_n(rst_n), .wr_strobe(wr), .rd_strobe(rd),
      .wr_addr(t_wa), .rd_addr(t_ra), .fill_level(t_lv), .can_write(t_cw), .can_read(t_cr));

   // Vector: {wr, rd, expected write offset, expected read offset, expected level}
   localparam int NV = 12;
   localparam logic [25:0] VEC [NV] = '{
      {1'b1, 1'b0, 8'd1, 8'd0, 8'd1},
      {1'b1, 1'b0, 8'd2, 8'd0, 8'd2},
      {1'b1, 1'b0, 8'd3, 8'd0, 8'd3},
      {1'b1, 1'b1, 8'd4, 8'd1, 8'd3},
      {1'b0, 1'b0, 8'd4, 8'd1, 8'd3},
      {1'b0, 1'b1, 8'd4, 8'd2, 8'd2},
      {1'b1, 1'b1, 8'd5, 8'd3, 8'd2},
      {1'b0, 1'b1, 8'd5, 8'd4, 8'd1},
      {1'b1, 1'b0, 8'd6, 8'd4, 8'd2},
      {1'b0, 1'b1, 8'd6, 8'd5, 8'd1},
      {1'b0, 1'b1, 8'd6, 8'd6, 8'd0},
      {1'b0, 1'b0, 8'd6, 8'd6, 8'd0}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive on a falling edge, pass one rising edge, return on the next falling edge.
   task automatic step(input logic w, input logic r);
      wr = w; rd = r;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr = 1'b0; rd = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic flags_for(input int lvl);
      chk("R8 main can_write", int'(m_cw), int'(lvl < 16));
      chk("R8 main can_read",  int'(m_cr), int'(lvl > 0));
      chk("R6 thr can_write",  int'(t_cw), int'(lvl < 12));
      chk("R7 thr can_read",   int'(t_cr), int'(lvl > 4));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(4 * 100000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int lvl;
      do_reset();
      // R1: reset state
      chk("R1 main wr_addr", int'(m_wa), M_BASE);
      chk("R1 main rd_addr", int'(m_ra), M_BASE);
      chk("R1 main level", int'(m_lv), 0);
      chk("R1 thr wr_addr", int'(t_wa), T_BASE);
      flags_for(0);

      // Table walk: R2, R3, R5
      for (int i = 0; i < NV; i++) begin
         logic [25:0] v;
         v = VEC[i];
         step(v[25], v[24]);
         chk("R2 write offset", int'(m_wa) - M_BASE, int'(v[23:16]));
         chk("R3 read offset",  int'(m_ra) - M_BASE, int'(v[15:8]));
         chk("R5 level",        int'(m_lv), int'(v[7:0]));
         chk("R9 thr write addr", int'(t_wa), T_BASE + int'(v[23:16]));
         flags_for(int'(v[7:0]));
      end

      // Wrap: 8 writes, then 16 paired cycles -> 24 writes, 16 reads
      do_reset();
      for (int i = 0; i < 8; i++) step(1'b1, 1'b0);
      for (int i = 0; i < 16; i++) step(1'b1, 1'b1);
      chk("R4 write offset wraps to 8", int'(m_wa) - M_BASE, 8);
      chk("R4 read offset wraps to 0",  int'(m_ra) - M_BASE, 0);
      chk("R5 paired keeps level", int'(m_lv), 8);
      step(1'b0, 1'b0);
      chk("R2 idle holds write addr", int'(m_wa) - M_BASE, 8);
      chk("R3 idle holds read addr",  int'(m_ra) - M_BASE, 0);

      // Climb through the thr write limit (12)
      lvl = 8;
      for (int i = 0; i < 4; i++) begin
         step(1'b1, 1'b0);
         lvl++;
         chk("R5 level climbs", int'(m_lv), lvl);
         flags_for(lvl);
      end
      // R10: write with thr can_write low still counts
      chk("R10 thr write flag low before write", int'(t_cw), 0);
      step(1'b1, 1'b0);
      lvl++;
      chk("R10 thr level advances past limit", int'(t_lv), 13);
      chk("R10 thr write addr advances", int'(t_wa), T_BASE + 13);
      for (int i = 0; i < 3; i++) begin
         step(1'b1, 1'b0);
         lvl++;
      end
      chk("R8 main full level", int'(m_lv), 16);
      chk("R4 write offset wraps at full", int'(m_wa) - M_BASE, 0);
      flags_for(16);

      // Drain to empty
      for (int i = 0; i < 16; i++) begin
         step(1'b0, 1'b1);
         lvl--;
         chk("R5 level drains", int'(m_lv), lvl);
         flags_for(lvl);
      end
      chk("R3 read offset after drain", int'(m_ra) - M_BASE, 0);
      chk("R9 main read addr at base", int'(m_ra), M_BASE);

      finish_run();
   end
endmodule